// File: doc/BRIEF.md
# Pointer-Register Address Generator

This block computes the effective data-memory address for a load or store in a small 8-bit processor. It also computes the write-back value for the 16-bit pointer pair that the instruction names. Each cycle it takes an addressing mode, a pointer select, a short unsigned displacement, a full direct address and the current contents of the three pointer pairs. One clock later it presents the address, a pointer-update strobe with the new pointer value and the pair it belongs to, and an error flag for combinations the architecture forbids.

The three pointers are the register pairs at the top of the general register file: the first pair holds registers 27:26, the second 29:28 and the third 31:30. The decode stage drives the mode and select fields. The register file consumes the update strobe, and the memory stage consumes the address.

Top module: `ptr_agen`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output is zero after that edge.
- R2: Mode code 0 (direct) gives `eff_addr` = `direct_addr`, for any pointer select and displacement, with `upd_en` = 0 and `err` = 0.
- R3: Mode code 1 (indirect) gives `eff_addr` = the selected pointer, with `upd_en` = 0. Select code 0 picks `ptr_x` (R27:R26), code 1 picks `ptr_y` (R29:R28) and code 2 picks `ptr_z` (R31:R30).
- R4: Mode code 2 (displacement) accepts select codes 1 and 2 only. It gives `eff_addr` = pointer + zero-extended `disp` (0 to 63), modulo 2^16, with `upd_en` = 0.
- R5: Mode code 3 (pre-decrement) gives `eff_addr` = pointer − 1 modulo 2^16, `upd_en` = 1, and `upd_val` equal to that same address.
- R6: Mode code 4 (post-increment) gives `eff_addr` = the unmodified pointer, `upd_en` = 1, and `upd_val` = pointer + 1 modulo 2^16.
- R7: The error case covers mode codes 5 to 7, select code 3 in any pointer mode, and select code 0 in displacement mode. In that case `err` = 1 and `upd_en`, `upd_val`, `upd_sel` and `eff_addr` are all 0.
- R8: When `upd_en` = 1, `upd_sel` equals the select code of the instruction. When `upd_en` = 0, both `upd_sel` and `upd_val` are 0.
- R9: Outputs are registered. A change at the inputs appears on the outputs only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Addressing mode code |
| ptr_sel | input | 2 | Pointer select code |
| disp | input | 6 | Unsigned displacement |
| direct_addr | input | 16 | Full direct address |
| ptr_x | input | 16 | Current first pointer pair |
| ptr_y | input | 16 | Current second pointer pair |
| ptr_z | input | 16 | Current third pointer pair |
| eff_addr | output | 16 | Effective data address |
| upd_en | output | 1 | Pointer write-back strobe |
| upd_sel | output | 2 | Pointer pair to write back |
| upd_val | output | 16 | New pointer value |
| err | output | 1 | Illegal mode/select combination |

## Verification
The assertions assume that the mode, select and pointer inputs are stable across the edge that samples them and known from the first clock after reset. They compare each registered output with the sampled input one cycle back. The bench drives every input only on the falling edge. It sweeps all eight mode codes, all four select codes and all 64 displacements over pointer sets chosen to make pre-decrement, post-increment and displacement wrap through zero. It therefore exercises the illegal codes along with the legal ones without leaving that stable-input regime.

// File: rtl/ptr_agen_pkg.sv
package ptr_agen_pkg;
  localparam int SEL_W  = 2;
  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] AM_DIRECT  = 3'd0;
  localparam logic [MODE_W-1:0] AM_IND     = 3'd1;
  localparam logic [MODE_W-1:0] AM_DISP    = 3'd2;
  localparam logic [MODE_W-1:0] AM_PREDEC  = 3'd3;
  localparam logic [MODE_W-1:0] AM_POSTINC = 3'd4;

  localparam logic [SEL_W-1:0] PS_X = 2'd0;
  localparam logic [SEL_W-1:0] PS_Y = 2'd1;
  localparam logic [SEL_W-1:0] PS_Z = 2'd2;

  typedef enum logic [1:0] {
    SRC_DIRECT = 2'd0,
    SRC_BASE   = 2'd1,
    SRC_OFFS   = 2'd2,
    SRC_DEC    = 2'd3
  } addr_src_e;
endpackage

// File: rtl/ptr_agen_sel.sv
module ptr_agen_sel
  import ptr_agen_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int NUM_PTR = 3
) (
  input  logic [NUM_PTR*ADDR_W-1:0] ptr_flat,
  input  logic [SEL_W-1:0]          sel,
  output logic [ADDR_W-1:0]         base,
  output logic                      sel_ok
);
  logic [ADDR_W-1:0] cand [NUM_PTR];

  genvar g;
  generate
    for (g = 0; g < NUM_PTR; g++) begin : g_unpack
      assign cand[g] = ptr_flat[g*ADDR_W +: ADDR_W];
    end
  endgenerate

  always_comb begin
    base   = '0;
    sel_ok = 1'b0;
    for (int i = 0; i < NUM_PTR; i++) begin
      if (sel == SEL_W'(i)) begin
        base   = cand[i];
        sel_ok = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ptr_agen_dec.sv
module ptr_agen_dec
  import ptr_agen_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [SEL_W-1:0]  sel,
  input  logic              sel_ok,
  output addr_src_e         src,
  output logic              upd_req,
  output logic              use_inc,
  output logic              illegal
);
  always_comb begin
    src     = SRC_DIRECT;
    upd_req = 1'b0;
    use_inc = 1'b0;
    illegal = 1'b0;
    unique case (mode)
      AM_DIRECT:  src = SRC_DIRECT;
      AM_IND: begin
        src     = SRC_BASE;
        illegal = !sel_ok;
      end
      AM_DISP: begin
        src     = SRC_OFFS;
        illegal = !sel_ok || (sel == PS_X);
      end
      AM_PREDEC: begin
        src     = SRC_DEC;
        upd_req = 1'b1;
        illegal = !sel_ok;
      end
      AM_POSTINC: begin
        src     = SRC_BASE;
        upd_req = 1'b1;
        use_inc = 1'b1;
        illegal = !sel_ok;
      end
      default: illegal = 1'b1;
    endcase
    if (illegal) upd_req = 1'b0;
  end
endmodule

// File: rtl/ptr_agen_arith.sv
module ptr_agen_arith #(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 6
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] offs_sum,
  output logic [ADDR_W-1:0] dec_val,
  output logic [ADDR_W-1:0] inc_val
);
  localparam int PAD_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;
  assign disp_ext = {{PAD_W{1'b0}}, disp};

  assign offs_sum = base + disp_ext;
  assign dec_val  = base - ADDR_W'(1);
  assign inc_val  = base + ADDR_W'(1);
endmodule

// File: rtl/ptr_agen.sv
module ptr_agen
  import ptr_agen_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode,
  input  logic [1:0]        ptr_sel,
  input  logic [DISP_W-1:0] disp,
  input  logic [ADDR_W-1:0] direct_addr,
  input  logic [ADDR_W-1:0] ptr_x,
  input  logic [ADDR_W-1:0] ptr_y,
  input  logic [ADDR_W-1:0] ptr_z,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              upd_en,
  output logic [1:0]        upd_sel,
  output logic [ADDR_W-1:0] upd_val,
  output logic              err
);
  localparam int NUM_PTR = 3;

  logic [ADDR_W-1:0] base, offs_sum, dec_val, inc_val;
  logic              sel_ok, upd_req, use_inc, illegal;
  addr_src_e         src;
  logic [ADDR_W-1:0] addr_d, upd_val_d;

  ptr_agen_sel #(.ADDR_W(ADDR_W), .NUM_PTR(NUM_PTR)) u_sel (
    .ptr_flat ({ptr_z, ptr_y, ptr_x}),
    .sel      (ptr_sel),
    .base     (base),
    .sel_ok   (sel_ok)
  );

  ptr_agen_dec u_dec (
    .mode    (mode),
    .sel     (ptr_sel),
    .sel_ok  (sel_ok),
    .src     (src),
    .upd_req (upd_req),
    .use_inc (use_inc),
    .illegal (illegal)
  );

  ptr_agen_arith #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_arith (
    .base     (base),
    .disp     (disp),
    .offs_sum (offs_sum),
    .dec_val  (dec_val),
    .inc_val  (inc_val)
  );

  always_comb begin
    unique case (src)
      SRC_DIRECT: addr_d = direct_addr;
      SRC_BASE:   addr_d = base;
      SRC_OFFS:   addr_d = offs_sum;
      default:    addr_d = dec_val;
    endcase
    if (illegal) addr_d = '0;
    upd_val_d = '0;
    if (upd_req) upd_val_d = use_inc ? inc_val : dec_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eff_addr <= '0;
      upd_en   <= 1'b0;
      upd_sel  <= '0;
      upd_val  <= '0;
      err      <= 1'b0;
    end else begin
      eff_addr <= addr_d;
      upd_en   <= upd_req;
      upd_sel  <= upd_req ? ptr_sel : '0;
      upd_val  <= upd_val_d;
      err      <= illegal;
    end
  end

  // R1: reset clears all outputs
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (eff_addr == '0 && !upd_en && upd_val == '0 && !err));

  // R2: direct mode passes the address through without an update
  a_r2_direct: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == AM_DIRECT && !$past(rst)) |->
      (eff_addr == $past(direct_addr) && !upd_en && !err));

  // R5: pre-decrement writes back the address it used
  a_r5_predec_wb: assert property (@(posedge clk) disable iff (rst)
    (upd_en && $past(mode) == AM_PREDEC) |-> (upd_val == eff_addr));

  // R6: post-increment writes back one above the address it used
  a_r6_postinc_wb: assert property (@(posedge clk) disable iff (rst)
    (upd_en && $past(mode) == AM_POSTINC) |-> (upd_val == eff_addr + ADDR_W'(1)));

  // R7: an error never comes with a pointer update
  a_r7_err_no_upd: assert property (@(posedge clk) disable iff (rst)
    err |-> (!upd_en && eff_addr == '0));

  // R8: the write-back target follows the select sampled one cycle earlier
  a_r8_upd_sel: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !$past(rst)) |-> (upd_sel == $past(ptr_sel)));
endmodule

// File: tb/ptr_agen_tb.sv
module ptr_agen_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  mode;
  logic [1:0]  ptr_sel;
  logic [5:0]  disp;
  logic [15:0] direct_addr, ptr_x, ptr_y, ptr_z;
  logic [15:0] eff_addr, upd_val;
  logic        upd_en, err;
  logic [1:0]  upd_sel;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  ptr_agen u_dut (
    .clk(clk), .rst(rst), .mode(mode), .ptr_sel(ptr_sel), .disp(disp),
    .direct_addr(direct_addr), .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z),
    .eff_addr(eff_addr), .upd_en(upd_en), .upd_sel(upd_sel),
    .upd_val(upd_val), .err(err)
  );

  logic [15:0] e_addr, e_val;
  logic        e_upd, e_err;
  logic [1:0]  e_sel;
  string       e_tag;

  task automatic model();
    logic [15:0] p;
    p = (ptr_sel == 2'd0) ? ptr_x : (ptr_sel == 2'd1) ? ptr_y : ptr_z;
    e_addr = 16'h0; e_val = 16'h0; e_upd = 1'b0; e_err = 1'b0; e_sel = 2'd0;
    case (mode)
      3'd0: begin e_tag = "R2"; e_addr = direct_addr; end
      3'd1: begin e_tag = "R3"; e_err = (ptr_sel == 2'd3); e_addr = p; end
      3'd2: begin e_tag = "R4"; e_err = (ptr_sel == 2'd3) || (ptr_sel == 2'd0);
                  e_addr = p + {10'd0, disp}; end
      3'd3: begin e_tag = "R5"; e_err = (ptr_sel == 2'd3); e_addr = p - 16'd1;
                  e_val = p - 16'd1; e_upd = 1'b1; end
      3'd4: begin e_tag = "R6"; e_err = (ptr_sel == 2'd3); e_addr = p;
                  e_val = p + 16'd1; e_upd = 1'b1; end
      default: begin e_tag = "R7"; e_err = 1'b1; end
    endcase
    if (e_err) begin
      e_tag = "R7"; e_addr = 16'h0; e_val = 16'h0; e_upd = 1'b0;
    end
    if (e_upd) e_sel = ptr_sel;
  endtask

  task automatic check_out(input string tag);
    n_chk++;
    if (eff_addr !== e_addr || upd_en !== e_upd || upd_val !== e_val || err !== e_err) begin
      n_bad++;
      $display("FAIL %s mode=%0d sel=%0d disp=%0d: addr/upd/val/err got %h/%b/%h/%b exp %h/%b/%h/%b",
               tag, mode, ptr_sel, disp, eff_addr, upd_en, upd_val, err,
               e_addr, e_upd, e_val, e_err);
    end
    n_chk++;
    if (upd_sel !== e_sel) begin
      n_bad++;
      $display("FAIL R8 mode=%0d sel=%0d: upd_sel got %0d exp %0d", mode, ptr_sel, upd_sel, e_sel);
    end
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] px [4];
    logic [15:0] py [4];
    logic [15:0] pz [4];
    px[0] = 16'h0000; py[0] = 16'h0000; pz[0] = 16'h0000;
    px[1] = 16'hFFFF; py[1] = 16'hFFFF; pz[1] = 16'hFFFF;
    px[2] = 16'h0001; py[2] = 16'hFFC1; pz[2] = 16'hFFE0;
    px[3] = 16'h1234; py[3] = 16'h8000; pz[3] = 16'h7FFF;

    rst = 1'b1; mode = 3'd3; ptr_sel = 2'd1; disp = 6'd5;
    direct_addr = 16'hBEEF; ptr_x = 16'h1111; ptr_y = 16'h2222; ptr_z = 16'h3333;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs held at zero under reset
    e_addr = 16'h0; e_val = 16'h0; e_upd = 1'b0; e_err = 1'b0; e_sel = 2'd0;
    check_out("R1");
    rst = 1'b0;

    // R9: new inputs are not visible before the next rising edge
    mode = 3'd0; direct_addr = 16'hA5A5;
    #5;
    n_chk++;
    if (eff_addr !== 16'h0) begin
      n_bad++;
      $display("FAIL R9 early output: got %h exp %h", eff_addr, 16'h0);
    end
    @(posedge clk); @(negedge clk);
    model();
    check_out("R9");

    for (int s = 0; s < 4; s++) begin
      for (int m = 0; m < 8; m++) begin
        for (int k = 0; k < 4; k++) begin
          for (int d = 0; d < 64; d++) begin
            ptr_x = px[s]; ptr_y = py[s]; ptr_z = pz[s];
            mode = 3'(m); ptr_sel = 2'(k); disp = 6'(d);
            direct_addr = 16'hC3A0 ^ (16'(d) * 16'd1031) ^ (16'(s) << 12);
            model();
            @(posedge clk); @(negedge clk);
            check_out(e_tag);
          end
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule